// File: doc/BRIEF.md
# Charge Enable and Soft-Start Sequencer

This block decides when a battery charger's power converter is allowed to run, and it shapes the charge-current reference once charging begins. Charging is permitted only after the adapter has been present for a programmable settling time. The active-low charge-enable pin must also have been held low for a programmable deglitch time. The power-path selector must permit charging, and no fault may be active. Every time is a parameter counted in clock cycles.

Once charging runs, the block ramps a 3-bit soft-start code. The current reference that follows is the programmed value times (code+1)/8, so code 0 gives 1/8 and code 7 gives the full value. The code advances one step after each programmable dwell. Any condition that withdraws permission stops the converter and zeroes the code in the same cycle, without waiting for a clock edge. A later restart always begins again at the lowest step.

Top module: `charge_seq`

## Requirements
- R1: After reset, `run_en` is 0, `ss_level` is 0 and `ramp_done` is 0.
- R2: `chg_en_n` is active low. While it is 1, `run_en` is 0 in that same cycle, and `ss_level` and `ramp_done` are 0 too.
- R3: A request on `chg_en_n` counts only after the pin has stayed low, with the adapter present, for `DEGLITCH_CYC` consecutive rising clock edges. Any single cycle high restarts that count. `run_en` rises on the edge after both qualifications are met.
- R4: `run_en` never rises before `adapter_ok` has been 1 for `ADAPT_DLY` consecutive rising edges.
- R5: While `adapter_ok` is 0, the state of `chg_en_n` has no effect. The pin deglitch count only begins once the adapter is present.
- R6: While running, `ss_level` starts at code 0 and increases by exactly one every `STEP_CYC` cycles. It stops at code 7 and holds there.
- R7: `ramp_done` is 1 exactly when `run_en` is 1 and `ss_level` is 7.
- R8: Any of the following drops `run_en` to 0 in the same cycle and forces `ss_level` to 0: `adapter_ok` low, `path_allow` low, or any bit of `fault` set.
- R9: After any stop, a restart begins at code 0. Losing the adapter restarts both the adapter delay and the pin deglitch in full. When a fault or the path selector clears, the restart follows one cycle after the condition clears, provided both delays are still satisfied.
- R10: `ss_level` code k means a reference of (k+1)/8 of the programmed value. The code reads 0 whenever `run_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| adapter_ok | input | 1 | Adapter voltage above its detect threshold |
| chg_en_n | input | 1 | Charge enable pin, low requests charging |
| path_allow | input | 1 | Power-path selector permits charging |
| fault | input | NUM_FLT | Fault flags, any set bit blocks charging |
| run_en | output | 1 | Converter run enable |
| ss_level | output | 3 | Soft-start code, reference = (code+1)/8 |
| ramp_done | output | 1 | Ramp has reached full reference |

## Verification
The hardest situations to reach involve the order of the two qualifying delays. Whichever delay is longer hides the other, so the bench drives two copies of the block from the same stimulus. In one copy the pin deglitch is the longer delay; in the other the adapter delay is. Each copy has its start cycle checked on the exact edge.

The rule that the pin is ignored without the adapter shows up only as a later start time. The bench therefore holds the pin low for many cycles with the adapter absent. It then checks that the start still waits the full deglitch after the adapter appears.

// File: rtl/chgseq_pkg.sv
package chgseq_pkg;

    localparam int LVL_W = 3;

    typedef logic [LVL_W-1:0] lvl_t;

    localparam lvl_t LVL_TOP = '1;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic adapter;
        logic pin_low;
        logic path;
        logic any_fault;
    } gate_in_s;

    function automatic lvl_t lvl_next(input lvl_t cur);
        return (cur == LVL_TOP) ? cur : cur + lvl_t'(1);
    endfunction

    function automatic logic gate_kill(input gate_in_s g);
        return !g.adapter || !g.pin_low || !g.path || g.any_fault;
    endfunction

endpackage

// File: rtl/chgseq_dwell.sv
module chgseq_dwell #(
    parameter int unsigned LIMIT = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic qual,
    output logic ready
);
    localparam int unsigned CW = $clog2(LIMIT + 1);
    typedef logic [CW-1:0] cnt_t;
    localparam cnt_t CMAX = cnt_t'(LIMIT);

    cnt_t cnt;

    always_ff @(posedge clk) begin
        if (rst || !qual) begin
            cnt <= '0;
        end else if (cnt != CMAX) begin
            cnt <= cnt + cnt_t'(1);
        end
    end

    assign ready = (cnt == CMAX);

    // R3 / R4: a qualified input is needed on the previous edge
    p_dwell_needs_qual_r3: assert property (@(posedge clk) disable iff (rst)
        ready |-> $past(qual));

    p_dwell_bound_r4: assert property (@(posedge clk) disable iff (rst)
        cnt <= CMAX);

endmodule

// File: rtl/chgseq_ramp.sv
module chgseq_ramp
    import chgseq_pkg::*;
#(
    parameter int unsigned STEP_CYC = 170
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    output lvl_t level,
    output logic at_top
);
    localparam int unsigned SW = (STEP_CYC > 1) ? $clog2(STEP_CYC) : 1;
    typedef logic [SW-1:0] step_t;
    localparam step_t SLAST = step_t'(STEP_CYC - 1);

    step_t tick;

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            tick  <= '0;
            level <= '0;
        end else if (tick == SLAST) begin
            tick  <= '0;
            level <= lvl_next(level);
        end else begin
            tick <= tick + step_t'(1);
        end
    end

    assign at_top = (level == LVL_TOP);

    // R6: the code moves by at most one per edge
    p_level_step_r6: assert property (@(posedge clk) disable iff (rst)
        $past(active) |-> (level == $past(level)) || (level == lvl_t'($past(level) + lvl_t'(1))));

    // R9: an inactive cycle drops the ramp back to the first step
    p_level_restart_r9: assert property (@(posedge clk) disable iff (rst)
        !$past(active) |-> (level == '0));

endmodule

// File: rtl/charge_seq.sv
module charge_seq
    import chgseq_pkg::*;
#(
    parameter int unsigned ADAPT_DLY    = 700,
    parameter int unsigned DEGLITCH_CYC = 200,
    parameter int unsigned STEP_CYC     = 170,
    parameter int unsigned NUM_FLT      = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               adapter_ok,
    input  logic               chg_en_n,
    input  logic               path_allow,
    input  logic [NUM_FLT-1:0] fault,
    output logic               run_en,
    output logic [LVL_W-1:0]   ss_level,
    output logic               ramp_done
);
    gate_in_s   gin;
    logic       kill;
    logic       adp_ready;
    logic       pin_ready;
    logic       go;
    logic       at_top;
    lvl_t       ramp_lvl;
    seq_state_e state;

    always_comb begin
        gin.adapter   = adapter_ok;
        gin.pin_low   = !chg_en_n;
        gin.path      = path_allow;
        gin.any_fault = |fault;
    end

    assign kill = gate_kill(gin);

    chgseq_dwell #(.LIMIT(ADAPT_DLY)) u_adapter_dwell (
        .clk   (clk),
        .rst   (rst),
        .qual  (gin.adapter),
        .ready (adp_ready)
    );

    // the pin is only evaluated while the adapter is present
    chgseq_dwell #(.LIMIT(DEGLITCH_CYC)) u_pin_dwell (
        .clk   (clk),
        .rst   (rst),
        .qual  (gin.adapter && gin.pin_low),
        .ready (pin_ready)
    );

    assign go = adp_ready && pin_ready && !kill;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: if (go)   state <= ST_RUN;
                ST_RUN:  if (kill) state <= ST_IDLE;
                default:           state <= ST_IDLE;
            endcase
        end
    end

    assign run_en = (state == ST_RUN) && !kill;

    chgseq_ramp #(.STEP_CYC(STEP_CYC)) u_ramp (
        .clk    (clk),
        .rst    (rst),
        .active (run_en),
        .level  (ramp_lvl),
        .at_top (at_top)
    );

    assign ss_level  = run_en ? ramp_lvl : '0;
    assign ramp_done = run_en && at_top;

    p_pin_high_off_r2: assert property (@(posedge clk) disable iff (rst)
        chg_en_n |-> !run_en);

    p_start_after_delays_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(run_en) |-> (adp_ready && pin_ready));

    p_pin_ignored_r5: assert property (@(posedge clk) disable iff (rst)
        !$past(adapter_ok) |-> !pin_ready);

    p_done_at_top_r7: assert property (@(posedge clk) disable iff (rst)
        ramp_done |-> (run_en && ss_level == LVL_TOP));

    p_kill_clears_r8: assert property (@(posedge clk) disable iff (rst)
        (!adapter_ok || !path_allow || (|fault)) |-> (!run_en && ss_level == '0));

    p_first_step_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(run_en) |-> (ss_level == '0));

    p_idle_zero_r10: assert property (@(posedge clk) disable iff (rst)
        !run_en |-> (ss_level == '0 && !ramp_done));

endmodule

// File: tb/test_charge_seq.sv
`timescale 1ns/1ps
module test_charge_seq;
    localparam int A_ADP = 24;
    localparam int A_DG  = 32;
    localparam int B_ADP = 40;
    localparam int B_DG  = 10;
    localparam int STEP  = 8;

    logic       clk = 1'b0;
    logic       rst;
    logic       adapter_ok;
    logic       chg_en_n;
    logic       path_allow;
    logic [3:0] fault;
    logic       a_run, b_run, a_done, b_done;
    logic [2:0] a_lvl, b_lvl;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    charge_seq #(.ADAPT_DLY(A_ADP), .DEGLITCH_CYC(A_DG), .STEP_CYC(STEP), .NUM_FLT(4)) i_charge_seq (
        .clk(clk), .rst(rst), .adapter_ok(adapter_ok), .chg_en_n(chg_en_n),
        .path_allow(path_allow), .fault(fault),
        .run_en(a_run), .ss_level(a_lvl), .ramp_done(a_done)
    );

    charge_seq #(.ADAPT_DLY(B_ADP), .DEGLITCH_CYC(B_DG), .STEP_CYC(STEP), .NUM_FLT(4)) i_charge_seq_b (
        .clk(clk), .rst(rst), .adapter_ok(adapter_ok), .chg_en_n(chg_en_n),
        .path_allow(path_allow), .fault(fault),
        .run_en(b_run), .ss_level(b_lvl), .ramp_done(b_done)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic go_idle();
        adapter_ok = 1'b0; chg_en_n = 1'b1; path_allow = 1'b1; fault = '0;
        step(2);
    endtask

    task automatic t_reset();
        rst = 1'b1; adapter_ok = 1'b0; chg_en_n = 1'b1; path_allow = 1'b1; fault = '0;
        step(3);
        rst = 1'b0;
        step(1);
        chk("R1", "run_en", a_run, 0);
        chk("R1", "ss_level", a_lvl, 0);
        chk("R1", "ramp_done", a_done, 0);
        chk("R1", "run_en b", b_run, 0);
    endtask

    task automatic t_delays();
        go_idle();
        adapter_ok = 1'b1; chg_en_n = 1'b0;
        step(A_DG);
        chk("R3", "run before deglitch", a_run, 0);
        chk("R4", "run b before adapter delay", b_run, 0);
        step(1);
        chk("R3", "run after deglitch", a_run, 1);
        chk("R4", "run b still waiting", b_run, 0);
        step(B_ADP - A_DG - 1);
        chk("R4", "run b one edge early", b_run, 0);
        step(1);
        chk("R4", "run b after adapter delay", b_run, 1);
        chk("R9", "b starts at code 0", b_lvl, 0);
    endtask

    task automatic t_ramp();
        go_idle();
        adapter_ok = 1'b1; chg_en_n = 1'b0;
        step(A_DG + 1);
        chk("R6", "first code", a_lvl, 0);
        chk("R7", "done low at start", a_done, 0);
        step(STEP - 1);
        chk("R6", "code before first step", a_lvl, 0);
        step(1);
        chk("R6", "code after first step", a_lvl, 1);
        step(5 * STEP);
        chk("R6", "code 6", a_lvl, 6);
        chk("R7", "done low at code 6", a_done, 0);
        step(STEP);
        chk("R6", "code 7", a_lvl, 7);
        chk("R7", "done at code 7", a_done, 1);
        step(4 * STEP);
        chk("R6", "holds at code 7", a_lvl, 7);
        chk("R7", "done held", a_done, 1);
        chg_en_n = 1'b1;
        #1;
        chk("R2", "pin high stops run", a_run, 0);
        chk("R10", "code zero when stopped", a_lvl, 0);
        chk("R7", "done cleared", a_done, 0);
        chk("R2", "pin high stops run b", b_run, 0);
    endtask

    task automatic t_glitch();
        // adapter stays present from the previous task
        step(1);
        chg_en_n = 1'b0;
        step(20);
        chg_en_n = 1'b1;
        step(1);
        chg_en_n = 1'b0;
        step(A_DG);
        chk("R3", "glitch restarts deglitch", a_run, 0);
        step(1);
        chk("R3", "run after full deglitch", a_run, 1);
    endtask

    task automatic t_kill();
        step(STEP);
        chk("R6", "code 1 before fault", a_lvl, 1);
        fault = 4'b0100;
        #1;
        chk("R8", "fault stops run", a_run, 0);
        chk("R8", "fault zeroes code", a_lvl, 0);
        step(1);
        fault = '0;
        #1;
        chk("R9", "idle right after fault clears", a_run, 0);
        step(1);
        chk("R9", "restart after fault", a_run, 1);
        chk("R9", "restart at code 0", a_lvl, 0);
        step(STEP);
        chk("R6", "code 1 after restart", a_lvl, 1);
        path_allow = 1'b0;
        #1;
        chk("R8", "path block stops run", a_run, 0);
        chk("R8", "path block zeroes code", a_lvl, 0);
        step(3);
        path_allow = 1'b1;
        step(1);
        chk("R9", "restart after path", a_run, 1);
        chk("R9", "path restart code 0", a_lvl, 0);
        adapter_ok = 1'b0;
        #1;
        chk("R8", "adapter loss stops run", a_run, 0);
        chk("R8", "adapter loss stops run b", b_run, 0);
        step(1);
        adapter_ok = 1'b1;
        step(A_DG);
        chk("R9", "full delay after adapter loss", a_run, 0);
        step(1);
        chk("R9", "run after full delay", a_run, 1);
        step(B_ADP - A_DG - 1);
        chk("R9", "b adapter delay restarted", b_run, 0);
        step(1);
        chk("R9", "b run after adapter delay", b_run, 1);
    endtask

    task automatic t_pin_ignored();
        go_idle();
        chg_en_n = 1'b0;
        step(60);
        chk("R5", "no run without adapter", a_run, 0);
        adapter_ok = 1'b1;
        step(A_ADP + 1);
        chk("R5", "pin time without adapter not counted", a_run, 0);
        step(A_DG - A_ADP - 1);
        chk("R5", "still waiting deglitch", a_run, 0);
        step(1);
        chk("R5", "run after deglitch with adapter", a_run, 1);
    endtask

    initial begin
        t_reset();
        t_delays();
        t_ramp();
        t_glitch();
        t_kill();
        t_pin_ignored();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

endmodule